// File: doc/BRIEF.md
# Masked Wrapping Burst Address Counter

This block generates addresses for a synchronous memory port. It holds three registers: a counter, a mask and a mirror. The mirror keeps the start address of a burst. Only the counter bits whose mask bit is 1 take part in counting. The counter bits whose mask bit is 0 keep their loaded value and act as a fixed base, so a burst cycles inside an aligned window of the address space.

When a step leaves every counting bit at 1, the active-low interrupt goes low. The next step restores the start address from the mirror. An optional input lets a low interrupt force a counter clear instead, so the burst restarts from the base with its counting field at zero. The current counter or mask value can be read back on a registered output.

All operations are selected each clock cycle from a small set of control inputs. Master reset has top priority. A group-select input then chooses between counter operations and mask operations.

Top module: `burst_addr_gen`

## Requirements
- R1: While `mrst_n` is low at a rising edge, the counter and mirror become 0, every mask bit becomes 1, `irq_n` becomes 1 and `addr_out` becomes 0.
- R2: A counter clear (`sel_cnt`=1, `op_clr`=1) sets to 0 those counter and mirror bits whose mask bit is 1, and leaves every other bit unchanged.
- R3: A counter load (`sel_cnt`=1, `op_load`=1, `op_clr`=0) copies `addr_in` into both the counter and the mirror.
- R4: A step (`sel_cnt`=1, `op_step`=1, no other op) changes only counter bits whose mask bit is 1. The counting field advances by one count, which is +1 when mask bit 0 is 1 and +2 when mask bit 0 is 0 and mask bit 1 is 1. A zero mask leaves the counter unchanged.
- R5: When the mask is nonzero and all counter bits under the mask are 1, a step loads the counter from the mirror. After any step, `irq_n` is 0 exactly when the mask is nonzero and all counter bits under the mask are 1.
- R6: A counter clear, counter load, mask clear or mask load drives `irq_n` to 1 on the next edge.
- R7: A cycle with no operation requested in the selected group keeps the counter, mask, mirror, `irq_n` and `addr_out` unchanged.
- R8: A counter read (`sel_cnt`=1, `op_read`=1) or mask read (`sel_cnt`=0, `op_read`=1) puts the register value on `addr_out` after the next rising edge. The output holds that value until the next read or master reset.
- R9: A mask clear (`sel_cnt`=0, `op_clr`=1) sets every mask bit to 1. A mask load (`sel_cnt`=0, `op_load`=1) copies `addr_in` into the mask. Neither changes the counter.
- R10: Within the counter group the priority is clear, then load, then read, then step. Within the mask group it is clear, then load, then read. `op_step` has no effect when `sel_cnt`=0.
- R11: With `loop_zero`=1 and `irq_n`=0, any counter-group cycle performs a counter clear, so the burst restarts at the base with its counting field at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| sel_cnt | input | 1 | 1 selects counter operations, 0 selects mask operations |
| op_clr | input | 1 | Clear request for the selected group |
| op_load | input | 1 | Load request from `addr_in` |
| op_read | input | 1 | Readback request to `addr_out` |
| op_step | input | 1 | Counter step request |
| loop_zero | input | 1 | Lets a low `irq_n` force a counter clear |
| addr_in | input | AW | Load value |
| addr_out | output | AW | Registered readback value |
| irq_n | output | 1 | Terminal-count flag, active low |

## Verification
Two kinds of operation can fall in the same cycle. The first is several operation requests within one group. The bench provokes this by raising clear and load together, load and read together, and read and step together. It then uses readback to confirm that only the higher-priority operation took effect. The second is the forced clear from a low `irq_n` combined with a step request while `loop_zero` is set. Here the expected result is the base address with its counting field at zero, not the mirror value. A bench model that scatters a compact count into the mask bits predicts every value for sweeps over several sparse and contiguous masks.

// File: rtl/bag_pkg.sv
package bag_pkg;

   typedef enum logic [3:0] {
      OP_HOLD  = 4'd0,
      OP_MRST  = 4'd1,
      OP_CCLR  = 4'd2,
      OP_CLOAD = 4'd3,
      OP_CREAD = 4'd4,
      OP_CSTEP = 4'd5,
      OP_KCLR  = 4'd6,
      OP_KLOAD = 4'd7,
      OP_KREAD = 4'd8
   } bag_op_e;

endpackage

// File: rtl/bag_decode.sv
module bag_decode
   import bag_pkg::*;
#(
   parameter bit LOOP_EN = 1'b1
) (
   input  logic    mrst_n,
   input  logic    sel_cnt,
   input  logic    op_clr,
   input  logic    op_load,
   input  logic    op_read,
   input  logic    op_step,
   input  logic    loop_zero,
   input  logic    irq_n,
   output bag_op_e op
);

   logic force_clr;

   generate
      if (LOOP_EN) begin : g_loop
         assign force_clr = loop_zero & ~irq_n;
      end else begin : g_noloop
         assign force_clr = loop_zero & 1'b0;
      end
   endgenerate

   always_comb begin
      op = OP_HOLD;
      if (!mrst_n) begin
         op = OP_MRST;
      end else if (sel_cnt) begin
         if (op_clr || force_clr) op = OP_CCLR;
         else if (op_load)        op = OP_CLOAD;
         else if (op_read)        op = OP_CREAD;
         else if (op_step)        op = OP_CSTEP;
      end else begin
         if (op_clr)              op = OP_KCLR;
         else if (op_load)        op = OP_KLOAD;
         else if (op_read)        op = OP_KREAD;
      end
   end

endmodule

// File: rtl/bag_step.sv
module bag_step #(
   parameter int AW    = 18,
   parameter int STYLE = 0
) (
   input  logic [AW-1:0] cnt,
   input  logic [AW-1:0] msk,
   input  logic [AW-1:0] mir,
   output logic [AW-1:0] nxt,
   output logic          term,
   output logic          full_after
);

   logic [AW-1:0] adv;

   initial begin
      if (STYLE != 0 && STYLE != 1) $fatal(1, "bag_step: STYLE must be 0 or 1");
   end

   generate
      if (STYLE == 0) begin : g_arith
         logic [AW-1:0] lsb_w;
         logic [AW-1:0] sum;
         assign lsb_w = msk & (~msk + {{(AW-1){1'b0}}, 1'b1});
         assign sum   = (cnt | ~msk) + lsb_w;
         assign adv   = (sum & msk) | (cnt & ~msk);
      end else begin : g_ripple
         always_comb begin
            logic carry;
            carry = 1'b1;
            for (int i = 0; i < AW; i++) begin
               if (msk[i]) begin
                  adv[i] = cnt[i] ^ carry;
                  carry  = carry & cnt[i];
               end else begin
                  adv[i] = cnt[i];
               end
            end
         end
      end
   endgenerate

   assign term       = (msk != '0) && ((cnt & msk) == msk);
   assign nxt        = term ? mir : adv;
   assign full_after = (msk != '0) && ((nxt & msk) == msk);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int AW         = 18,
   parameter int STEP_STYLE = 0,
   parameter bit LOOP_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          sel_cnt,
   input  logic          op_clr,
   input  logic          op_load,
   input  logic          op_read,
   input  logic          op_step,
   input  logic          loop_zero,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out,
   output logic          irq_n
);

   localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};
   localparam logic [AW-1:0] ALL_ZERO = {AW{1'b0}};

   initial begin
      if (AW < 2 || AW > 32) $fatal(1, "burst_addr_gen: AW out of range 2..32");
   end

   bag_op_e       op;
   logic [AW-1:0] cnt_q, msk_q, mir_q;
   logic [AW-1:0] step_nxt;
   logic          step_term, step_full;

   bag_decode #(.LOOP_EN(LOOP_EN)) u_dec (
      .mrst_n    (mrst_n),
      .sel_cnt   (sel_cnt),
      .op_clr    (op_clr),
      .op_load   (op_load),
      .op_read   (op_read),
      .op_step   (op_step),
      .loop_zero (loop_zero),
      .irq_n     (irq_n),
      .op        (op)
   );

   bag_step #(.AW(AW), .STYLE(STEP_STYLE)) u_step (
      .cnt        (cnt_q),
      .msk        (msk_q),
      .mir        (mir_q),
      .nxt        (step_nxt),
      .term       (step_term),
      .full_after (step_full)
   );

   always_ff @(posedge clk) begin
      unique case (op)
         OP_MRST: begin
            cnt_q    <= ALL_ZERO;
            mir_q    <= ALL_ZERO;
            msk_q    <= ALL_ONES;
            irq_n    <= 1'b1;
            addr_out <= ALL_ZERO;
         end
         OP_CCLR: begin
            cnt_q <= cnt_q & ~msk_q;
            mir_q <= mir_q & ~msk_q;
            irq_n <= 1'b1;
         end
         OP_CLOAD: begin
            cnt_q <= addr_in;
            mir_q <= addr_in;
            irq_n <= 1'b1;
         end
         OP_CREAD: addr_out <= cnt_q;
         OP_CSTEP: begin
            cnt_q <= step_nxt;
            irq_n <= ~step_full;
         end
         OP_KCLR: begin
            msk_q <= ALL_ONES;
            irq_n <= 1'b1;
         end
         OP_KLOAD: begin
            msk_q <= addr_in;
            irq_n <= 1'b1;
         end
         OP_KREAD: addr_out <= msk_q;
         default: ;
      endcase
   end

   p_mrst_state_r1: assert property (@(posedge clk)
      !mrst_n |=> (irq_n && cnt_q == ALL_ZERO && mir_q == ALL_ZERO && msk_q == ALL_ONES))
      else $error("R1 master reset state wrong");

   p_load_both_r3: assert property (@(posedge clk) disable iff (!mrst_n)
      (op == OP_CLOAD) |=> (cnt_q == $past(addr_in) && mir_q == $past(addr_in)))
      else $error("R3 load mismatch");

   p_masked_fixed_r4: assert property (@(posedge clk) disable iff (!mrst_n)
      (op == OP_CSTEP && !step_term) |=> (((cnt_q ^ $past(cnt_q)) & ~msk_q) == ALL_ZERO))
      else $error("R4 masked bit changed");

   p_wrap_mirror_r5: assert property (@(posedge clk) disable iff (!mrst_n)
      (op == OP_CSTEP && step_term) |=> (cnt_q == $past(mir_q)))
      else $error("R5 wrap not to mirror");

   p_irq_release_r6: assert property (@(posedge clk) disable iff (!mrst_n)
      (op == OP_CCLR || op == OP_CLOAD || op == OP_KCLR || op == OP_KLOAD) |=> irq_n)
      else $error("R6 irq not released");

   p_hold_r7: assert property (@(posedge clk) disable iff (!mrst_n)
      (op == OP_HOLD) |=> ($stable(cnt_q) && $stable(msk_q) && $stable(mir_q)
                           && $stable(irq_n) && $stable(addr_out)))
      else $error("R7 hold changed state");

   p_readback_r8: assert property (@(posedge clk) disable iff (!mrst_n)
      (op == OP_CREAD) |=> (addr_out == $past(cnt_q)))
      else $error("R8 readback mismatch");

   p_mask_only_r9: assert property (@(posedge clk) disable iff (!mrst_n)
      (op == OP_KLOAD || op == OP_KCLR) |=> $stable(cnt_q))
      else $error("R9 counter touched by mask op");

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

   localparam int AW = 18;
   localparam logic [AW-1:0] ONES = {AW{1'b1}};

   logic clk = 1'b0;
   logic mrst_n, sel_cnt, op_clr, op_load, op_read, op_step, loop_zero;
   logic [AW-1:0] addr_in, addr_out;
   logic irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [AW-1:0] m_cnt, m_msk, m_mir, m_out;
   logic m_irq;

   always #5 clk = ~clk;

   burst_addr_gen #(.AW(AW)) u0 (
      .clk(clk), .mrst_n(mrst_n), .sel_cnt(sel_cnt), .op_clr(op_clr),
      .op_load(op_load), .op_read(op_read), .op_step(op_step),
      .loop_zero(loop_zero), .addr_in(addr_in), .addr_out(addr_out), .irq_n(irq_n)
   );

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] advance(input logic [AW-1:0] c, input logic [AW-1:0] k);
      logic [AW-1:0] v, r;
      int n;
      v = '0; n = 0;
      for (int i = 0; i < AW; i++) if (k[i]) begin v[n] = c[i]; n++; end
      v = v + 1'b1;
      r = c; n = 0;
      for (int i = 0; i < AW; i++) if (k[i]) begin r[i] = v[n]; n++; end
      return r;
   endfunction

   function automatic bit all_set(input logic [AW-1:0] c, input logic [AW-1:0] k);
      return (k != '0) && ((c & k) == k);
   endfunction

   task automatic run(input logic s, input logic c, input logic l, input logic rd,
                      input logic st, input logic lz, input logic [AW-1:0] a, input string req);
      @(negedge clk);
      mrst_n = 1'b1; sel_cnt = s; op_clr = c; op_load = l; op_read = rd;
      op_step = st; loop_zero = lz; addr_in = a;
      @(posedge clk);
      #2;
      if (s) begin
         if (c || (lz && !m_irq)) begin
            m_cnt = m_cnt & ~m_msk; m_mir = m_mir & ~m_msk; m_irq = 1'b1;
         end else if (l) begin
            m_cnt = a; m_mir = a; m_irq = 1'b1;
         end else if (rd) begin
            m_out = m_cnt;
         end else if (st) begin
            m_cnt = all_set(m_cnt, m_msk) ? m_mir : advance(m_cnt, m_msk);
            m_irq = !all_set(m_cnt, m_msk);
         end
      end else begin
         if (c) begin m_msk = ONES; m_irq = 1'b1; end
         else if (l) begin m_msk = a; m_irq = 1'b1; end
         else if (rd) m_out = m_msk;
      end
      check({req, " irq_n"}, {{(AW-1){1'b0}}, irq_n}, {{(AW-1){1'b0}}, m_irq});
      check({req, " addr_out"}, addr_out, m_out);
      op_clr = 0; op_load = 0; op_read = 0; op_step = 0; loop_zero = 0;
   endtask

   task automatic rd_cnt(input string req);
      run(1, 0, 0, 1, 0, 0, '0, req);
   endtask

   task automatic rd_msk(input string req);
      run(0, 0, 0, 1, 0, 0, '0, req);
   endtask

   initial begin
      #(10 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] masks [6];
      masks[0] = 18'h0003F; masks[1] = 18'h0003E; masks[2] = 18'h00005;
      masks[3] = 18'h30011; masks[4] = 18'h3F000; masks[5] = 18'h00000;

      mrst_n = 0; sel_cnt = 0; op_clr = 0; op_load = 0; op_read = 0;
      op_step = 0; loop_zero = 0; addr_in = '0;
      repeat (3) @(posedge clk);
      #2;
      m_cnt = '0; m_mir = '0; m_msk = ONES; m_irq = 1'b1; m_out = '0;
      // R1 reset state
      check("R1 irq_n", {{(AW-1){1'b0}}, irq_n}, {{(AW-1){1'b0}}, 1'b1});
      check("R1 addr_out", addr_out, '0);
      rd_cnt("R1 counter");
      rd_msk("R1 mask");

      // R9 mask load, R3 counter load, R8 readback; example walk R4/R5
      run(0, 0, 1, 0, 0, 0, 18'h0003F, "R9 mask load");
      rd_msk("R9 R8 mask read");
      run(1, 0, 1, 0, 0, 0, 18'h2A408, "R3 load");
      rd_cnt("R3 R8 count read");
      for (int i = 0; i < 60; i++) begin
         run(1, 0, 0, 0, 1, 0, '0, "R4 R5 example step");
         rd_cnt("R4 R5 example read");
      end

      // R7 hold while irq low
      while (m_irq) run(1, 0, 0, 0, 1, 0, '0, "R5 to terminal");
      for (int i = 0; i < 4; i++) run(1, 0, 0, 0, 0, 0, 18'h12345, "R7 hold counter group");
      run(0, 0, 0, 0, 1, 0, 18'h12345, "R10 R7 step ignored in mask group");
      rd_cnt("R7 R10 after hold");
      // R6 release by mask load
      run(0, 0, 1, 0, 0, 0, 18'h0003F, "R6 mask load release");

      // sweeps over masks: R4 R5 R3
      for (int m = 0; m < 6; m++) begin
         int len;
         len = (1 << $countones(masks[m])) + 3;
         run(0, 0, 1, 0, 0, 0, masks[m], "R9 sweep mask");
         run(1, 0, 1, 0, 0, 0, 18'h15A5A ^ (m * 18'h01111), "R3 sweep load");
         for (int i = 0; i < len; i++) begin
            run(1, 0, 0, 0, 1, 0, '0, "R4 R5 sweep step");
            rd_cnt("R4 R5 sweep read");
         end
      end

      // R2 partial clear, then wrap returns to cleared mirror
      run(0, 0, 1, 0, 0, 0, 18'h0000F, "R9 mask 0F");
      run(1, 0, 1, 0, 0, 0, 18'h003A5, "R3 load 3A5");
      run(1, 0, 0, 0, 1, 0, '0, "R4 step");
      run(1, 1, 0, 0, 0, 0, '0, "R2 clear");
      rd_cnt("R2 cleared value");
      for (int i = 0; i < 17; i++) begin
         run(1, 0, 0, 0, 1, 0, '0, "R2 R5 mirror cleared");
         rd_cnt("R2 R5 read");
      end

      // R6 release by counter clear and counter load and mask clear
      while (m_irq) run(1, 0, 0, 0, 1, 0, '0, "R5 reach");
      run(1, 1, 0, 0, 0, 0, '0, "R6 clear release");
      while (m_irq) run(1, 0, 0, 0, 1, 0, '0, "R5 reach");
      run(1, 0, 1, 0, 0, 0, 18'h0000F, "R6 load release");
      run(0, 1, 0, 0, 0, 0, '0, "R6 R9 mask clear release");
      rd_msk("R9 mask clear value");

      // R10 priority within groups
      run(0, 0, 1, 0, 0, 0, 18'h000F0, "R9 mask F0");
      run(1, 0, 1, 0, 0, 0, 18'h11111, "R3 load");
      run(1, 1, 1, 0, 0, 0, 18'h3FFFF, "R10 clear over load");
      rd_cnt("R10 clear won");
      run(1, 0, 1, 1, 0, 0, 18'h22222, "R10 load over read");
      rd_cnt("R10 load won");
      run(1, 0, 0, 1, 1, 0, '0, "R10 read over step");
      rd_cnt("R10 no step");
      run(0, 1, 1, 0, 0, 0, 18'h00003, "R10 mask clear over load");
      rd_msk("R10 mask clear won");
      run(0, 0, 1, 1, 0, 0, 18'h00003, "R10 mask load over read");
      rd_msk("R10 mask load won");

      // R11 loop to zero field
      run(0, 0, 1, 0, 0, 0, 18'h00007, "R9 mask 7");
      run(1, 0, 1, 0, 0, 0, 18'h00012, "R3 load 12");
      while (m_irq) run(1, 0, 0, 0, 1, 0, '0, "R11 reach terminal");
      run(1, 0, 0, 0, 1, 1, '0, "R11 forced clear");
      rd_cnt("R11 base with zero field");
      check("R11 value", addr_out, 18'h00010);
      run(1, 0, 0, 0, 1, 1, '0, "R11 normal step after");
      rd_cnt("R11 step from zero");

      // R1 master reset mid-run
      @(negedge clk); mrst_n = 0;
      @(posedge clk); #2;
      m_cnt = '0; m_mir = '0; m_msk = ONES; m_irq = 1'b1; m_out = '0;
      check("R1 mid reset addr_out", addr_out, '0);
      rd_cnt("R1 counter after reset");
      rd_msk("R1 mask after reset");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule